// File: doc/BRIEF.md
# Two-Client Guarded FIFO

A synchronous first-in first-out buffer shared by two clients. Each operation is offered as a guarded method. Enqueue and dequeue each have a per-client request input, a ready output and an enable input. The head value is a value method with a ready output and no enable. A client raises its request without waiting for anything. The block then grants at most one enqueuer and one dequeuer in each cycle. A client's ready is high only when it holds the grant and the buffer can take the operation.

A client that pulses its enable only while its ready is high can never overflow the buffer, underflow it, or collide with the other client. An enable raised without ready is dropped. When both clients request the same operation, round-robin arbitration settles it. Each arbiter moves its preference only when a contested grant is actually used. In the same cycle, one enqueue and one dequeue can both complete.

Top module: `gfifo2_top`

## Requirements
- R1: A synchronous active-low reset empties the buffer and makes client 0 the preferred client of both arbiters. Right after reset, head_rdy and deq_rdy are 0. With both clients requesting enqueue, enq_rdy is 2'b01.
- R2: enq_rdy[i] is high only when client i holds the enqueue grant and the occupancy is below DEPTH.
- R3: deq_rdy[i] is high only when client i holds the dequeue grant and the buffer is not empty. head_rdy is high exactly when the buffer is not empty.
- R4: A client that requests alone holds the grant. A client that does not request never sees its ready high. Bit i of every request, enable and ready vector belongs to client i.
- R5: When both clients request the same operation, the preferred client wins. The preference passes to the other client once a contested grant is consumed by an enable. A contested grant that is not consumed leaves the preference unchanged.
- R6: Items leave in the order they were accepted, whichever client supplied them.
- R7: head_data shows the oldest item while head_rdy is high. It stays unchanged in any cycle without a dequeue, including a cycle with an enqueue.
- R8: An enqueue and a dequeue accepted in the same cycle leave the occupancy unchanged.
- R9: An enable on a port whose ready is low has no effect on contents, occupancy or arbitration.
- R10: With DEPTH items stored, no enqueue ready is given.
- R11: At most one enqueue ready and at most one dequeue ready are high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enq_req | input | 2 | Enqueue request per client |
| enq_en | input | 2 | Enqueue enable per client |
| enq_data0 | input | WIDTH | Data offered by client 0 |
| enq_data1 | input | WIDTH | Data offered by client 1 |
| enq_rdy | output | 2 | Enqueue ready per client |
| deq_req | input | 2 | Dequeue request per client |
| deq_en | input | 2 | Dequeue enable per client |
| deq_rdy | output | 2 | Dequeue ready per client |
| head_rdy | output | 1 | Head value valid (buffer not empty) |
| head_data | output | WIDTH | Oldest stored item |

## Verification
Suppose the occupancy counter drifts from the true contents. The ports then show it within one cycle of the next boundary: enq_rdy is still offered at DEPTH items, or head_rdy stays high after the last item has left. A stuck or inverted arbiter preference shows on the first contested cycle, when the wrong client's ready rises. A read pointer that is off by one shows on the next head_data check as an item out of order. Every check is made on ready values sampled before the edge and on head values that can be predicted from the queue contents.

// File: rtl/gfifo2_pkg.sv
package gfifo2_pkg;

  // Round-robin pick among two requesters; pri names the favoured client.
  function automatic logic [1:0] rr_pick(input logic [1:0] req, input logic pri);
    if (req == 2'b11) rr_pick = pri ? 2'b10 : 2'b01;
    else              rr_pick = req;
  endfunction

  // Occupancy step for one cycle of push/pop.
  function automatic logic [7:0] occ_step(input logic [7:0] occ, input logic push, input logic pop);
    case ({push, pop})
      2'b10:   occ_step = occ + 8'd1;
      2'b01:   occ_step = occ - 8'd1;
      default: occ_step = occ;
    endcase
  endfunction

endpackage

// File: rtl/gfifo2_rr_arb.sv
module gfifo2_rr_arb
  import gfifo2_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req,
  input  logic       take,
  output logic [1:0] gnt
);
  logic pri;
  logic contest_used;

  assign gnt          = rr_pick(req, pri);
  assign contest_used = (req == 2'b11) && take;

  always_ff @(posedge clk) begin
    if (!rst_n)            pri <= 1'b0;
    else if (contest_used) pri <= ~pri;
  end
endmodule

// File: rtl/gfifo2_store.sv
module gfifo2_store
  import gfifo2_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    occ,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [7:0]       occ_wide;

  assign occ_wide = occ_step(8'(occ), push, pop);
  assign full     = (occ == CW'(DEPTH));
  assign empty    = (occ == '0);
  assign dout     = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      occ <= occ_wide[CW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end
endmodule

// File: rtl/gfifo2_top.sv
module gfifo2_top
  import gfifo2_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       enq_req,
  input  logic [1:0]       enq_en,
  input  logic [WIDTH-1:0] enq_data0,
  input  logic [WIDTH-1:0] enq_data1,
  output logic [1:0]       enq_rdy,
  input  logic [1:0]       deq_req,
  input  logic [1:0]       deq_en,
  output logic [1:0]       deq_rdy,
  output logic             head_rdy,
  output logic [WIDTH-1:0] head_data
);
  logic [1:0]       enq_gnt, deq_gnt;
  logic [1:0]       enq_fire, deq_fire;
  logic             do_enq, do_deq;
  logic             full, empty;
  logic [CW-1:0]    occ;
  logic [WIDTH-1:0] din;

  gfifo2_rr_arb u_enq_arb (.clk(clk), .rst_n(rst_n), .req(enq_req), .take(do_enq), .gnt(enq_gnt));
  gfifo2_rr_arb u_deq_arb (.clk(clk), .rst_n(rst_n), .req(deq_req), .take(do_deq), .gnt(deq_gnt));

  assign enq_rdy  = enq_gnt & {2{~full}};
  assign deq_rdy  = deq_gnt & {2{~empty}};
  assign head_rdy = ~empty;

  assign enq_fire = enq_en & enq_rdy;
  assign deq_fire = deq_en & deq_rdy;
  assign do_enq   = |enq_fire;
  assign do_deq   = |deq_fire;
  assign din      = enq_fire[1] ? enq_data1 : enq_data0;

  gfifo2_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push(do_enq), .pop(do_deq), .din(din),
    .dout(head_data), .occ(occ), .full(full), .empty(empty)
  );
endmodule

// File: rtl/gfifo2_chk.sv
module gfifo2_chk #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       enq_req,
  input logic [1:0]       enq_gnt,
  input logic [1:0]       deq_req,
  input logic [1:0]       deq_gnt,
  input logic [1:0]       enq_rdy,
  input logic [1:0]       deq_rdy,
  input logic             head_rdy,
  input logic [WIDTH-1:0] head_data,
  input logic             do_enq,
  input logic             do_deq,
  input logic [CW-1:0]    occ
);
  p_enq_excl_r11: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(enq_rdy));
  p_deq_excl_r11: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(deq_rdy));
  p_full_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == CW'(DEPTH)) |-> (enq_rdy == 2'b00));
  p_empty_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> (deq_rdy == 2'b00 && !head_rdy));
  p_no_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((enq_rdy & ~enq_req) == 2'b00) && ((deq_rdy & ~deq_req) == 2'b00));
  p_occ_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (do_enq && do_deq) |=> (occ == $past(occ)));
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!do_enq && !do_deq) |=> $stable(occ));
  p_head_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (head_rdy && !do_deq) |=> (head_rdy && $stable(head_data)));
  p_enq_rr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_req == 2'b11 && do_enq) |=> (enq_req != 2'b11 || enq_gnt != $past(enq_gnt)));
  p_deq_rr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_req == 2'b11 && do_deq) |=> (deq_req != 2'b11 || deq_gnt != $past(deq_gnt)));
endmodule

bind gfifo2_top gfifo2_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .enq_req(enq_req), .enq_gnt(enq_gnt),
  .deq_req(deq_req), .deq_gnt(deq_gnt), .enq_rdy(enq_rdy), .deq_rdy(deq_rdy),
  .head_rdy(head_rdy), .head_data(head_data), .do_enq(do_enq), .do_deq(do_deq),
  .occ(occ)
);

// File: tb/gfifo2_top_bench.sv
module gfifo2_top_bench;
  localparam int W = 8;
  localparam int N = 15;
  // {enq_req, deq_req, exp enq_rdy, exp deq_rdy, exp head_rdy, exp head}
  localparam logic [16:0] VEC [N] = '{
    {2'b11, 2'b00, 2'b01, 2'b00, 1'b0, 8'h00},
    {2'b11, 2'b01, 2'b10, 2'b01, 1'b1, 8'h11},
    {2'b11, 2'b11, 2'b01, 2'b01, 1'b1, 8'h22},
    {2'b10, 2'b11, 2'b10, 2'b10, 1'b1, 8'h13},
    {2'b01, 2'b00, 2'b01, 2'b00, 1'b1, 8'h24},
    {2'b10, 2'b00, 2'b10, 2'b00, 1'b1, 8'h24},
    {2'b01, 2'b00, 2'b01, 2'b00, 1'b1, 8'h24},
    {2'b11, 2'b00, 2'b00, 2'b00, 1'b1, 8'h24},
    {2'b11, 2'b10, 2'b00, 2'b10, 1'b1, 8'h24},
    {2'b11, 2'b00, 2'b10, 2'b00, 1'b1, 8'h15},
    {2'b00, 2'b01, 2'b00, 2'b01, 1'b1, 8'h15},
    {2'b00, 2'b01, 2'b00, 2'b01, 1'b1, 8'h26},
    {2'b00, 2'b01, 2'b00, 2'b01, 1'b1, 8'h17},
    {2'b00, 2'b01, 2'b00, 2'b01, 1'b1, 8'h2A},
    {2'b00, 2'b01, 2'b00, 2'b00, 1'b0, 8'h00}
  };

  logic clk = 0, rst_n = 0;
  logic [1:0] enq_req = 0, enq_en = 0, deq_req = 0, deq_en = 0;
  logic [W-1:0] enq_data0 = 0, enq_data1 = 0;
  logic [1:0] enq_rdy, deq_rdy;
  logic head_rdy;
  logic [W-1:0] head_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gfifo2_top #(.WIDTH(W), .DEPTH(4)) u_gfifo2_top (
    .clk(clk), .rst_n(rst_n), .enq_req(enq_req), .enq_en(enq_en),
    .enq_data0(enq_data0), .enq_data1(enq_data1), .enq_rdy(enq_rdy),
    .deq_req(deq_req), .deq_en(deq_en), .deq_rdy(deq_rdy),
    .head_rdy(head_rdy), .head_data(head_data)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    enq_req = 2'b11; deq_req = 2'b11;
    #1;
    check("R1 enq_rdy after reset", 32'(enq_rdy), 32'h1);
    check("R1 deq_rdy after reset", 32'(deq_rdy), 32'h0);
    check("R1 head_rdy after reset", 32'(head_rdy), 32'h0);

    // Table walk: R2 R3 R4 R5 R6 R8 R10 R11; enables follow ready.
    for (int i = 0; i < N; i++) begin
      enq_en = 0; deq_en = 0;
      enq_req = VEC[i][16:15];
      deq_req = VEC[i][14:13];
      enq_data0 = {4'h1, 4'(i + 1)};
      enq_data1 = {4'h2, 4'(i + 1)};
      #1;
      check($sformatf("R2/R5/R10 enq_rdy step %0d", i + 1), 32'(enq_rdy), 32'(VEC[i][12:11]));
      check($sformatf("R3/R4/R5 deq_rdy step %0d", i + 1), 32'(deq_rdy), 32'(VEC[i][10:9]));
      check($sformatf("R3 head_rdy step %0d", i + 1), 32'(head_rdy), 32'(VEC[i][8]));
      if (VEC[i][8])
        check($sformatf("R6/R8 head_data step %0d", i + 1), 32'(head_data), 32'(VEC[i][7:0]));
      enq_en = enq_rdy;
      deq_en = deq_rdy;
      step();
    end
    enq_en = 0; deq_en = 0; enq_req = 0; deq_req = 0;

    // R9: enables without ready on an empty buffer
    enq_req = 2'b01; enq_data0 = 8'h55; enq_data1 = 8'hEE;
    #1;
    check("R9 enq_rdy client0 only", 32'(enq_rdy), 32'h1);
    enq_en = 2'b10; deq_en = 2'b11;
    step();
    enq_en = 0; deq_en = 0; enq_req = 0;
    #1;
    check("R9 no push from ungranted enable", 32'(head_rdy), 32'h0);

    // push one item, then illegal dequeue enables
    @(negedge clk);
    enq_req = 2'b01; enq_data0 = 8'h5A; enq_en = 2'b01;
    step();
    enq_req = 0; enq_en = 0;
    #1;
    check("R7 head after push", 32'(head_data), 32'h5A);
    deq_req = 2'b01; deq_en = 2'b10;
    step();
    deq_req = 0; deq_en = 0;
    #1;
    check("R9 head_rdy kept", 32'(head_rdy), 32'h1);
    check("R9 R7 head kept", 32'(head_data), 32'h5A);

    // R5: unconsumed contest leaves preference at client 0
    @(negedge clk);
    enq_req = 2'b11;
    #1;
    check("R5 enq contest grant", 32'(enq_rdy), 32'h1);
    step();
    #1;
    check("R5 unconsumed contest keeps grant", 32'(enq_rdy), 32'h1);
    // R7: enqueue while non-empty keeps head
    enq_en = 2'b01; enq_data0 = 8'h66;
    step();
    enq_en = 0; enq_req = 0;
    #1;
    check("R7 head unchanged by enqueue", 32'(head_data), 32'h5A);

    // R1: reset with contents
    @(negedge clk);
    rst_n = 0;
    step();
    rst_n = 1;
    enq_req = 2'b11;
    #1;
    check("R1 head_rdy after mid reset", 32'(head_rdy), 32'h0);
    check("R1 preference after mid reset", 32'(enq_rdy), 32'h1);
    enq_req = 0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule